// File: doc/BRIEF.md
# MDIO Management Master with Register Front End

This block runs management transactions to a PHY or serdes over a two-wire MDIO link (a clock, MDC, and a bidirectional data line). Software drives it through two 32-bit registers. The control register selects the MDC divisor and whether a preamble goes out first. It also reports completion and activity. The frame register holds the complete 32-bit serial frame (start, opcode, PHY address, register address, turnaround and data) exactly as it appears on the wire, most significant bit first.

Writing a frame word with its start bit set launches one transaction. For a write, all 32 bits are shifted out. For a read, the master drives the header and then releases the data line from the turnaround onward. It collects the 16 returned bits and places them in the low half of the frame register. Software polls the completion flag, reads the result, and then writes zero to the control register to clear the flag and the preamble enable.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the control register reads 0, MDC is low and the data-line output enable is low.
- R2: Writing the frame register (select 1) with bit 30 set while idle starts a transaction, and control bit 9 (busy) reads 1 from the next cycle. A frame write with bit 30 clear only stores the word: no MDC edge appears and busy stays 0.
- R3: While a transaction runs, MDC spends divisor+1 clocks low and then divisor+1 clocks high in each bit period. The divisor is sampled at launch. MDC stays low while idle.
- R4: If control bit 7 was set at launch, 32 MDC periods with the data line driven high come before the frame.
- R5: Frame bits go out from bit 31 down to bit 0, one per MDC period, and change only while MDC is low. A frame without bit 29 set drives all 32 bits with the output enable high.
- R6: A frame with bit 29 set (read) drives bits 31..18 and holds the output enable low for bits 17..0. The master samples the input at the MDC rising edge of bits 15..0, most significant first. On completion it stores the 16 bits in frame register bits 15..0 and keeps bits 31..16 as written.
- R7: Control bit 8 (done) becomes 1 and busy becomes 0 on the same clock edge. That edge is exactly bits×2×(divisor+1) clocks after the launching edge, where bits is 32 or 64 with the preamble.
- R8: Any control write (select 0) loads bit 7 and the low divisor bits and clears done. Writing zero returns the control register to 0.
- R9: A frame write while busy is ignored. The frame register and the serial sequence are unchanged.
- R10: Control readback puts the divisor in bits DIV_W-1..0, the preamble enable in bit 7, done in bit 8 and busy in bit 9. All other bits read 0, and done and busy cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 control, 1 frame |
| reg_wdata | input | 32 | Write data |
| rd_sel | input | 1 | Readback select: 0 control, 1 frame |
| rd_data | output | 32 | Readback value of the selected register |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line value from the pad |

## Verification
The hardest situation to reach from the ports is a second frame write landing while the shifter is mid-frame. The bench issues one right after a launch and then lets the scoreboard confirm that the wire sequence carries no extra or altered bits and that the stored word is untouched. The read path needs a PHY model that changes its bit after each sampled rising edge. This lets the bench show that the sampling happens on the rising edge and that the upper half of the frame word survives the capture.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam int FRAME_BITS   = 32;
    localparam int FRM_START    = 30;
    localparam int FRM_RD       = 29;
    localparam int FRM_RELEASE  = 17;
    localparam int FRM_DATA_TOP = 15;
    localparam int CTL_PRE      = 7;
    localparam int CTL_DONE     = 8;
    localparam int CTL_BUSY     = 9;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PRE   = 2'd1,
        PH_FRAME = 2'd2
    } phase_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_evt,
    output logic             fall_evt
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } clk_st_t;

    clk_st_t st_d, st_q;
    logic    wrap;

    assign wrap = run && (st_q.cnt == div);

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = !st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc      = st_q.mdc;
    assign rise_evt = wrap && !st_q.mdc;
    assign fall_evt = wrap && st_q.mdc;

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !mdc); // R3
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W   = 4,
    parameter int PRE_LEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [31:0]      launch_word,
    input  logic             launch_pre,
    input  logic [DIV_W-1:0] launch_div,
    input  logic             rise_evt,
    input  logic             fall_evt,
    input  logic             mdio_in,
    output logic             run,
    output logic [DIV_W-1:0] div_eff,
    output logic             finish,
    output logic [15:0]      capture,
    output logic             mdio_out,
    output logic             mdio_oe
);
    localparam int PRE_W = $clog2(PRE_LEN);
    localparam int CNT_W = (PRE_W > 5) ? PRE_W : 5;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [31:0]      word;
        logic             is_rd;
        logic [DIV_W-1:0] div;
        logic [15:0]      shreg;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic   last_bit;

    assign last_bit = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (launch) begin
            st_d.ph    = launch_pre ? PH_PRE : PH_FRAME;
            st_d.cnt   = launch_pre ? CNT_W'(PRE_LEN - 1) : CNT_W'(FRAME_BITS - 1);
            st_d.word  = launch_word;
            st_d.is_rd = launch_word[FRM_RD];
            st_d.div   = launch_div;
            st_d.shreg = '0;
        end else begin
            if (st_q.ph == PH_FRAME && st_q.is_rd && rise_evt &&
                st_q.cnt <= CNT_W'(FRM_DATA_TOP)) begin
                st_d.shreg = {st_q.shreg[14:0], mdio_in};
            end
            if (fall_evt) begin
                if (last_bit) begin
                    if (st_q.ph == PH_PRE) begin
                        st_d.ph  = PH_FRAME;
                        st_d.cnt = CNT_W'(FRAME_BITS - 1);
                    end else begin
                        st_d.ph = PH_IDLE;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        mdio_out = 1'b1;
        mdio_oe  = 1'b0;
        case (st_q.ph)
            PH_PRE: begin
                mdio_out = 1'b1;
                mdio_oe  = 1'b1;
            end
            PH_FRAME: begin
                mdio_out = st_q.word[st_q.cnt[4:0]];
                mdio_oe  = !(st_q.is_rd && st_q.cnt <= CNT_W'(FRM_RELEASE));
            end
            default: begin
                mdio_out = 1'b1;
                mdio_oe  = 1'b0;
            end
        endcase
    end

    assign run     = (st_q.ph != PH_IDLE);
    assign div_eff = st_q.div;
    assign finish  = (st_q.ph == PH_FRAME) && fall_evt && last_bit;
    assign capture = st_q.shreg;

    AST_LAUNCH_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (st_q.ph == PH_IDLE)); // R9
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             sel,
    input  logic [31:0]      wdata,
    input  logic             busy,
    input  logic             finish,
    input  logic [15:0]      capture,
    output logic             launch,
    output logic             pre_en,
    output logic [DIV_W-1:0] div,
    output logic             done,
    output logic [31:0]      frame
);
    typedef struct packed {
        logic             pre;
        logic [DIV_W-1:0] div;
        logic             done;
        logic [31:0]      frame;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        launch = 1'b0;
        if (finish) begin
            st_d.done = 1'b1;
            if (st_q.frame[FRM_RD]) st_d.frame[15:0] = capture;
        end
        if (wr && !sel) begin
            st_d.pre  = wdata[CTL_PRE];
            st_d.div  = wdata[DIV_W-1:0];
            st_d.done = 1'b0;
        end
        if (wr && sel && !busy) begin
            st_d.frame = wdata;
            if (wdata[FRM_START]) begin
                launch    = 1'b1;
                st_d.done = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pre_en = st_q.pre;
    assign div    = st_q.div;
    assign done   = st_q.done;
    assign frame  = st_q.frame;

    AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel && busy && !finish) |=> $stable(st_q.frame)); // R9
    AST_CTRL_WR_CLR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !sel) |=> !st_q.done); // R8
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W   = 4,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    input  logic        rd_sel,
    output logic [31:0] rd_data,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    logic             launch, pre_en, done, busy, finish;
    logic             rise_evt, fall_evt;
    logic [DIV_W-1:0] div_reg, div_eff;
    logic [31:0]      frame;
    logic [15:0]      capture;
    logic [31:0]      ctrl_view;

    mdio_regs #(.DIV_W(DIV_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .busy    (busy),
        .finish  (finish),
        .capture (capture),
        .launch  (launch),
        .pre_en  (pre_en),
        .div     (div_reg),
        .done    (done),
        .frame   (frame)
    );

    mdio_shifter #(.DIV_W(DIV_W), .PRE_LEN(PRE_LEN)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_word (reg_wdata),
        .launch_pre  (pre_en),
        .launch_div  (div_reg),
        .rise_evt    (rise_evt),
        .fall_evt    (fall_evt),
        .mdio_in     (mdio_in),
        .run         (busy),
        .div_eff     (div_eff),
        .finish      (finish),
        .capture     (capture),
        .mdio_out    (mdio_out),
        .mdio_oe     (mdio_oe)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .div      (div_eff),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    always_comb begin
        ctrl_view              = '0;
        ctrl_view[DIV_W-1:0]   = div_reg;
        ctrl_view[CTL_PRE]     = pre_en;
        ctrl_view[CTL_DONE]    = done;
        ctrl_view[CTL_BUSY]    = busy;
    end

    assign rd_data = rd_sel ? frame : ctrl_view;

    AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && (mdio_out != $past(mdio_out))) |-> !mdc); // R5
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done})); // R7
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> (!mdio_oe && !mdc)); // R1
endmodule

// File: tb/tb_mdio_mgmt_master.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_master;
    localparam int DIV_W   = 4;
    localparam int PRE_LEN = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        mdc, mdio_out, mdio_oe, mdio_in;

    always #2 clk = ~clk;

    mdio_mgmt_master #(.DIV_W(DIV_W), .PRE_LEN(PRE_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    // scoreboard item: kind 0 preamble, 1 driven frame bit, 2 released bit
    typedef struct packed {
        logic [1:0] kind;
        logic       val;
        logic       rdbit;
    } exp_t;

    exp_t        exp_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    int          tim_err = 0;
    int          exp_half = 1;
    bit          skip_low = 1'b1;
    logic [15:0] phy_shift = '0;

    assign mdio_in = phy_shift[15];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // monitor: compares each MDC rising edge against the scoreboard
    initial begin
        logic prev;
        int   run_len;
        exp_t it;
        prev = 1'b0;
        run_len = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (mdc != prev) begin
                    if (prev) begin
                        if (run_len != exp_half) tim_err++;
                    end else begin
                        if (!skip_low && run_len != exp_half) tim_err++;
                        skip_low = 1'b0;
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R2", "unexpected MDC edge", 32'(mdc), 32'h0);
                        end else begin
                            it = exp_q.pop_front();
                            case (it.kind)
                                2'd0: chk(mdio_oe && mdio_out, "R4", "preamble bit",
                                          {30'h0, mdio_oe, mdio_out}, 32'h3);
                                2'd1: chk(mdio_oe && (mdio_out == it.val), "R5", "frame bit",
                                          {30'h0, mdio_oe, mdio_out}, {30'h0, 1'b1, it.val});
                                default: chk(!mdio_oe, "R6", "released bit",
                                          32'(mdio_oe), 32'h0);
                            endcase
                            if (it.rdbit) phy_shift = {phy_shift[14:0], 1'b0};
                        end
                    end
                    run_len = 1;
                end else begin
                    run_len++;
                end
                prev = mdc;
            end
        end
    end

    task automatic reg_write(input logic sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_sel = sel;
        reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic do_xfer(input logic [31:0] word, input bit pre,
                           input logic [DIV_W-1:0] div, input logic [15:0] rd16,
                           input bit poke_busy);
        logic [31:0] v;
        int          cyc0;
        int          k;
        int          nbits;
        bit          is_rd;
        is_rd = word[29];
        reg_write(1'b0, {24'h0, pre, 3'b000, 4'(div)});
        phy_shift = rd16;
        exp_half = int'(div) + 1;
        tim_err = 0;
        skip_low = 1'b1;
        nbits = pre ? PRE_LEN + 32 : 32;
        if (pre) for (int i = 0; i < PRE_LEN; i++) exp_q.push_back('{2'd0, 1'b1, 1'b0});
        for (int i = 31; i >= 0; i--) begin
            if (is_rd && i <= 17) exp_q.push_back('{2'd2, 1'b0, (i <= 15)});
            else                  exp_q.push_back('{2'd1, word[i], 1'b0});
        end
        reg_write(1'b1, word);
        cyc0 = cyc;
        rd(1'b0, v);
        chk(v[9] == 1'b1 && v[8] == 1'b0, "R2", "busy after launch", v, 32'h200);
        if (poke_busy) begin
            reg_write(1'b1, 32'h6000_ABCD);
            rd(1'b1, v);
            chk(v == word, "R9", "frame while busy", v, word);
        end
        forever begin
            rd(1'b0, v);
            if (v[8] || (cyc - cyc0) > 5000) break;
            @(negedge clk);
        end
        k = nbits * 2 * (int'(div) + 1);
        chk((cyc - cyc0) == k, "R7", "done latency", 32'(cyc - cyc0), 32'(k));
        chk(v[9] == 1'b0 && v[8] == 1'b1, "R7", "done/busy", v[9:8], 2'b01);
        chk(exp_q.size() == 0, "R5", "bits left", 32'(exp_q.size()), 32'h0);
        chk(tim_err == 0, "R3", "MDC half periods", 32'(tim_err), 32'h0);
        rd(1'b1, v);
        if (is_rd) chk(v == {word[31:16], rd16}, "R6", "read capture", v, {word[31:16], rd16});
        else       chk(v == word, "R9", "frame kept", v, word);
        reg_write(1'b0, 32'h0);
        rd(1'b0, v);
        chk(v == 32'h0, "R8", "control cleared", v, 32'h0);
        exp_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rd(1'b0, v);
        chk(v == 32'h0, "R1", "control at reset", v, 32'h0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "pins at reset", {mdc, mdio_oe}, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(1'b0, v);
        chk(v == 32'h0, "R1", "control after reset", v, 32'h0);

        // R10: layout and read-only bits
        reg_write(1'b0, 32'h0000_03FF);
        rd(1'b0, v);
        chk(v == 32'h0000_008F, "R10", "control layout", v, 32'h8F);
        reg_write(1'b0, 32'h0000_0003);
        rd(1'b0, v);
        chk(v == 32'h0000_0003, "R8", "control reload", v, 32'h3);

        // R2: frame stored without start bit
        reg_write(1'b1, 32'h2000_1234);
        repeat (20) @(negedge clk);
        rd(1'b0, v);
        chk(v[9] == 1'b0 && mdc == 1'b0, "R2", "no launch without start", {v[9], mdc}, 2'b00);
        rd(1'b1, v);
        chk(v == 32'h2000_1234, "R2", "stored frame", v, 32'h2000_1234);

        // write frame, no preamble, divisor 0
        do_xfer({2'b01, 2'b01, 5'd3, 5'd9, 2'b10, 16'hA5C3}, 1'b0, 4'd0, 16'h0, 1'b0);
        // read frame with preamble, divisor 2
        do_xfer({2'b01, 2'b10, 5'd1, 5'd2, 2'b10, 16'h0}, 1'b1, 4'd2, 16'h9E35, 1'b0);
        // write with preamble, divisor 1, frame poked while busy
        do_xfer({2'b01, 2'b01, 5'd31, 5'd0, 2'b10, 16'h0F0F}, 1'b1, 4'd1, 16'h0, 1'b1);
        // read edge pattern, divisor 3
        do_xfer({2'b01, 2'b10, 5'd7, 5'd31, 2'b10, 16'h0}, 1'b0, 4'd3, 16'h8001, 1'b0);
        // read all ones with preamble, divisor 0
        do_xfer({2'b01, 2'b10, 5'd0, 5'd1, 2'b10, 16'h0}, 1'b1, 4'd0, 16'hFFFF, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule